// File: doc/BRIEF.md
# Hold/Acknowledge Bus Requester

This block wins bus mastership for a DMA engine over a two-wire handshake. It raises a hold request and waits for the host to answer with a hold acknowledge, then tells the DMA sequencer it may run its bus cycles. A request is triggered either by the receive/transmit FIFO crossing its threshold or by the need to touch a descriptor area. The memory area the DMA engine is working in is given as a code. The block latches that code when it raises the request, and it uses the code to decide what to do if the host withdraws the acknowledge early.

When a block transfer finishes, or when the DMA engine moves to a different memory area, the block adds one holding clock before it lets go of the request. This keeps it from contending with the next master. It never raises a request while the acknowledge is still active from a previous owner. An edge-select input chooses whether the request pin changes on the falling bus-clock edge (the default) or on the next rising edge.

Top module: `hold_bus_requester`

## Requirements
- R1: An active-low synchronous reset leaves holdReq, busGranted and statusActive at 0.
- R2: When fifoReq or descReq is high, the block is idle and the sampled acknowledge is inactive, statusActive rises on the next rising edge and holdReq follows.
- R3: holdAck is registered on the rising edge. busGranted rises on the second rising edge after holdAck goes high while requesting, and is never high unless the registered acknowledge was high on the previous edge.
- R4: With edgeSel=0, holdReq changes on the falling edge that follows the rising edge where the request decision is made. With edgeSel=1, it changes on the next rising edge instead.
- R5: While the registered acknowledge is high, no new request is raised. The request is raised only after the acknowledge has been sampled low.
- R6: xferDone while granted drops busGranted on the next edge. holdReq stays asserted for one extra holding clock and is then released.
- R7: A change of areaIn while granted (area codes: 00 data buffer, 01 descriptor, 10 CAM load, 11 descriptor) ends the block exactly like xferDone. The request is dropped, and a new one is raised only afterwards.
- R8: If the acknowledge is withdrawn during a descriptor-area block (area 01 or 11), busGranted drops, holdReq is deasserted for exactly one clock and is then reasserted.
- R9: If the acknowledge is withdrawn during a data-buffer block (area 00), the block returns to idle. holdReq is reasserted only if fifoReq is still high.
- R10: If the acknowledge is withdrawn during a CAM-load block (area 10), busGranted drops and statusActive reads idle, but holdReq stays asserted. Mastership resumes when the acknowledge returns.
- R11: If completion (xferDone) and preemption are seen on the same edge, completion wins. The holding clock runs and the block then goes idle without a resume request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoReq | input | 1 | FIFO threshold reached |
| descReq | input | 1 | Descriptor area access needed |
| areaIn | input | 2 | Memory area code of the pending work |
| edgeSel | input | 1 | 0: request launched on falling edge, 1: on rising edge |
| holdAck | input | 1 | Hold acknowledge from the host |
| xferDone | input | 1 | Last DMA cycle of the block completed |
| holdReq | output | 1 | Hold request to the host |
| busGranted | output | 1 | DMA sequencer may run bus cycles |
| statusActive | output | 1 | Requester busy (low when idle or parked) |

## Verification
Completion and preemption can land on the same edge: the DMA engine signals its last cycle just as the host's withdrawn acknowledge reaches the registered copy. The bench provokes this by dropping holdAck one clock before pulsing xferDone, inside a descriptor-area block. It then judges the outcome from statusActive and holdReq. A correct block shows one holding clock followed by idle with the request low. A block that gives preemption priority would instead back off and raise the request again.

// File: rtl/busreq_pkg.sv
package busreq_pkg;
  localparam int AREA_W = 2;

  typedef enum logic [AREA_W-1:0] {
    AREA_DATA     = 2'b00,
    AREA_DESC     = 2'b01,
    AREA_CAM      = 2'b10,
    AREA_DESC_ALT = 2'b11
  } areaT;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_XFER    = 3'd2,
    ST_HOLD    = 3'd3,
    ST_BACKOFF = 3'd4,
    ST_PARK    = 3'd5
  } stateT;

  typedef struct packed {
    logic reqWant;
    logic latchArea;
  } ctlStrobeT;
endpackage

// File: rtl/busreq_dp.sv
module busreq_dp
  import busreq_pkg::*;
#(
  parameter int ACK_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              holdAck,
  input  logic [AREA_W-1:0] areaIn,
  input  logic              edgeSel,
  input  ctlStrobeT         strb,
  output logic              ackQ,
  output areaT              areaQ,
  output logic              holdReq
);

  // Acknowledge capture on the rising edge; depth picked by parameter
  generate
    if (ACK_STAGES <= 1) begin : g_ackOne
      always_ff @(posedge clk) begin
        if (!rstN) ackQ <= 1'b0;
        else       ackQ <= holdAck;
      end
    end else begin : g_ackChain
      logic [ACK_STAGES-1:0] ackPipe;
      always_ff @(posedge clk) begin
        if (!rstN) ackPipe <= '0;
        else       ackPipe <= {ackPipe[ACK_STAGES-2:0], holdAck};
      end
      assign ackQ = ackPipe[ACK_STAGES-1];
    end
  endgenerate

  // Area latched when a new request starts
  always_ff @(posedge clk) begin
    if (!rstN)               areaQ <= AREA_DATA;
    else if (strb.latchArea) areaQ <= areaT'(areaIn);
  end

  // Launch pair: one copy on each clock edge, edgeSel picks the pin source
  logic reqFall;
  logic reqRise;

  always_ff @(negedge clk) begin
    if (!rstN) reqFall <= 1'b0;
    else       reqFall <= strb.reqWant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqRise <= 1'b0;
    else       reqRise <= strb.reqWant;
  end

  assign holdReq = edgeSel ? reqRise : reqFall;

  // R4: pin follows the chosen launch edge
  p_launch_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    edgeSel |-> holdReq == $past(strb.reqWant));
  p_launch_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    !edgeSel |-> holdReq == strb.reqWant);

endmodule

// File: rtl/busreq_ctrl.sv
module busreq_ctrl
  import busreq_pkg::*;
#(
  parameter int HOLD_CYCLES    = 1,
  parameter int BACKOFF_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoReq,
  input  logic              descReq,
  input  logic              xferDone,
  input  logic [AREA_W-1:0] areaIn,
  input  logic              ackQ,
  input  areaT              areaQ,
  output ctlStrobeT         strb,
  output logic              busGranted,
  output logic              statusActive
);

  localparam int MAX_WAIT = (HOLD_CYCLES > BACKOFF_CYCLES) ? HOLD_CYCLES : BACKOFF_CYCLES;
  localparam int CNT_W    = ($clog2(MAX_WAIT + 1) < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] BACK_LOAD = CNT_W'(BACKOFF_CYCLES - 1);

  stateT            state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             areaChg;
  logic             wantBus;

  assign areaChg = (areaIn != areaQ);
  assign wantBus = fifoReq | descReq;

  always_comb begin
    stateNext      = state;
    cntNext        = cnt;
    strb.latchArea = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (wantBus && !ackQ) begin
          stateNext      = ST_REQ;
          strb.latchArea = 1'b1;
        end
      end
      ST_REQ: begin
        if (ackQ) stateNext = ST_XFER;
      end
      ST_XFER: begin
        if (xferDone || areaChg) begin
          stateNext = ST_HOLD;
          cntNext   = HOLD_LOAD;
        end else if (!ackQ) begin
          unique case (areaQ)
            AREA_DATA: stateNext = ST_IDLE;
            AREA_CAM:  stateNext = ST_PARK;
            default: begin
              stateNext = ST_BACKOFF;
              cntNext   = BACK_LOAD;
            end
          endcase
        end
      end
      ST_HOLD: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_BACKOFF: begin
        if (cnt == '0) stateNext = ackQ ? ST_IDLE : ST_REQ;
        else           cntNext   = cnt - 1'b1;
      end
      ST_PARK: begin
        if (ackQ) stateNext = ST_XFER;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strb.reqWant = (state == ST_REQ) || (state == ST_XFER) ||
                   (state == ST_HOLD) || (state == ST_PARK);
    busGranted   = (state == ST_XFER);
    statusActive = (state == ST_REQ) || (state == ST_XFER) ||
                   (state == ST_HOLD) || (state == ST_BACKOFF);
  end

  p_grant_acked_r3: assert property (@(posedge clk) disable iff (!rstN)
    busGranted |-> $past(ackQ));
  p_req_after_ack_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.reqWant) |-> !$past(ackQ));
  p_hold_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busGranted && xferDone) |=> (!busGranted && strb.reqWant));
  p_backoff_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BACKOFF && cnt == '0) |=> (state != ST_BACKOFF));
  p_cam_park_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busGranted && !ackQ && !xferDone && !areaChg && areaQ == AREA_CAM)
      |=> (strb.reqWant && !statusActive && !busGranted));

endmodule

// File: rtl/hold_bus_requester.sv
module hold_bus_requester
  import busreq_pkg::*;
#(
  parameter int ACK_STAGES     = 1,
  parameter int HOLD_CYCLES    = 1,
  parameter int BACKOFF_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoReq,
  input  logic       descReq,
  input  logic [1:0] areaIn,
  input  logic       edgeSel,
  input  logic       holdAck,
  input  logic       xferDone,
  output logic       holdReq,
  output logic       busGranted,
  output logic       statusActive
);

  ctlStrobeT strb;
  logic      ackQ;
  areaT      areaQ;

  busreq_ctrl #(
    .HOLD_CYCLES   (HOLD_CYCLES),
    .BACKOFF_CYCLES(BACKOFF_CYCLES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fifoReq     (fifoReq),
    .descReq     (descReq),
    .xferDone    (xferDone),
    .areaIn      (areaIn),
    .ackQ        (ackQ),
    .areaQ       (areaQ),
    .strb        (strb),
    .busGranted  (busGranted),
    .statusActive(statusActive)
  );

  busreq_dp #(
    .ACK_STAGES(ACK_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .holdAck(holdAck),
    .areaIn (areaIn),
    .edgeSel(edgeSel),
    .strb   (strb),
    .ackQ   (ackQ),
    .areaQ  (areaQ),
    .holdReq(holdReq)
  );

endmodule

// File: tb/hold_bus_requester_tb.sv
module hold_bus_requester_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoReq = 1'b0;
  logic       descReq = 1'b0;
  logic [1:0] areaIn = 2'b00;
  logic       edgeSel = 1'b0;
  logic       holdAck = 1'b0;
  logic       xferDone = 1'b0;
  logic       holdReq, busGranted, statusActive;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  hold_bus_requester u_dut (
    .clk(clk), .rstN(rstN), .fifoReq(fifoReq), .descReq(descReq),
    .areaIn(areaIn), .edgeSel(edgeSel), .holdAck(holdAck), .xferDone(xferDone),
    .holdReq(holdReq), .busGranted(busGranted), .statusActive(statusActive)
  );

  // Row: {fifo, desc, area[1:0], ack, done, expHoldReq, expGranted, expStatus}
  localparam logic [8:0] VEC [18] = '{
    9'b1_0_00_0_0_000, 9'b1_0_00_1_0_001, 9'b1_0_00_1_0_101, 9'b0_0_00_1_1_111,
    9'b0_0_00_1_0_101, 9'b0_0_00_0_0_100, 9'b0_1_01_0_0_000, 9'b0_1_01_1_0_001,
    9'b0_1_01_1_0_101, 9'b0_1_01_0_0_111, 9'b0_1_01_0_0_111, 9'b0_1_01_0_0_101,
    9'b0_1_01_1_0_001, 9'b0_1_01_1_0_101, 9'b0_1_01_1_1_111, 9'b0_0_01_1_0_101,
    9'b0_0_01_0_0_100, 9'b0_0_00_0_0_000
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic f, input logic d, input logic [1:0] a,
                       input logic k, input logic x);
    fifoReq = f; descReq = d; areaIn = a; holdAck = k; xferDone = x;
  endtask

  task automatic doReset(input logic sel);
    rstN = 1'b0;
    edgeSel = sel;
    drive(0, 0, 2'b00, 0, 0);
    repeat (3) step();
    rstN = 1'b1;
  endtask

  // Reach the granted state for a given area; ends one step into the grant
  task automatic acquire(input logic f, input logic d, input logic [1:0] a);
    drive(f, d, a, 0, 0);
    step();
    holdAck = 1'b1;
    step();
    step();
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

  initial begin
    // R1 reset state
    doReset(1'b0);
    check("R1 holdReq after reset", holdReq, 1'b0);
    check("R1 busGranted after reset", busGranted, 1'b0);
    check("R1 statusActive after reset", statusActive, 1'b0);

    // Table: R2 request, R3 grant, R6 holding clock, R8 descriptor preemption
    for (int i = 0; i < 18; i++) begin
      check($sformatf("R6 table row %0d holdReq", i), holdReq, VEC[i][2]);
      check($sformatf("R3 table row %0d busGranted", i), busGranted, VEC[i][1]);
      check($sformatf("R2 table row %0d statusActive", i), statusActive, VEC[i][0]);
      drive(VEC[i][8], VEC[i][7], VEC[i][6:5], VEC[i][4], VEC[i][3]);
      step();
    end

    // R4 falling-edge launch
    doReset(1'b0);
    drive(1, 0, 2'b00, 0, 0);
    step();
    check("R4 fall mode before falling edge", holdReq, 1'b0);
    #2.5;
    check("R4 fall mode after falling edge", holdReq, 1'b1);

    // R4 rising-edge launch
    doReset(1'b1);
    drive(1, 0, 2'b00, 0, 0);
    step();
    check("R4 rise mode before falling edge", holdReq, 1'b0);
    #2.5;
    check("R4 rise mode after falling edge", holdReq, 1'b0);
    step();
    check("R4 rise mode next rising edge", holdReq, 1'b1);

    // R5 acknowledge already active
    doReset(1'b0);
    holdAck = 1'b1;
    step();
    step();
    fifoReq = 1'b1;
    step();
    check("R5 no request while ack high", statusActive, 1'b0);
    step();
    check("R5 holdReq low while ack high", holdReq, 1'b0);
    holdAck = 1'b0;
    step();
    check("R5 still idle one edge after ack low", statusActive, 1'b0);
    step();
    check("R5 request after ack sampled low", statusActive, 1'b1);
    step();
    check("R5 holdReq raised", holdReq, 1'b1);

    // R9 data preemption, threshold still high
    doReset(1'b0);
    acquire(1, 0, 2'b00);
    check("R9 granted", busGranted, 1'b1);
    holdAck = 1'b0;
    step();
    step();
    check("R9 grant dropped", busGranted, 1'b0);
    check("R9 idle after preempt", statusActive, 1'b0);
    step();
    check("R9 re-request status", statusActive, 1'b1);
    check("R9 holdReq low one clock", holdReq, 1'b0);
    step();
    check("R9 holdReq reasserted", holdReq, 1'b1);

    // R9 data preemption, threshold gone
    doReset(1'b0);
    acquire(1, 0, 2'b00);
    drive(0, 0, 2'b00, 0, 0);
    step();
    step();
    step();
    check("R9 no re-request status", statusActive, 1'b0);
    check("R9 no re-request holdReq", holdReq, 1'b0);
    step();
    check("R9 holdReq stays low", holdReq, 1'b0);

    // R10 CAM-load preemption
    doReset(1'b0);
    acquire(0, 1, 2'b10);
    check("R10 granted", busGranted, 1'b1);
    holdAck = 1'b0;
    step();
    step();
    check("R10 grant dropped", busGranted, 1'b0);
    check("R10 status idle while parked", statusActive, 1'b0);
    step();
    check("R10 holdReq kept", holdReq, 1'b1);
    holdAck = 1'b1;
    step();
    step();
    check("R10 regranted", busGranted, 1'b1);
    // R1 reset in the middle of a grant
    rstN = 1'b0;
    step();
    check("R1 grant cleared by reset", busGranted, 1'b0);
    check("R1 status cleared by reset", statusActive, 1'b0);
    #2.5;
    check("R1 holdReq cleared by reset", holdReq, 1'b0);
    rstN = 1'b1;

    // R7 area change ends the block
    doReset(1'b0);
    acquire(0, 1, 2'b01);
    check("R7 granted", busGranted, 1'b1);
    drive(0, 0, 2'b00, 1, 0);
    step();
    check("R7 grant ends on area change", busGranted, 1'b0);
    check("R7 holding clock active", statusActive, 1'b1);
    step();
    check("R7 idle after holding clock", statusActive, 1'b0);
    check("R7 holdReq kept during holding clock", holdReq, 1'b1);
    step();
    check("R7 holdReq dropped", holdReq, 1'b0);

    // R11 completion and preemption on the same edge
    doReset(1'b0);
    acquire(0, 1, 2'b01);
    holdAck = 1'b0;
    step();
    xferDone = 1'b1;
    step();
    check("R11 grant dropped", busGranted, 1'b0);
    check("R11 holding clock", statusActive, 1'b1);
    drive(0, 0, 2'b01, 0, 0);
    step();
    check("R11 idle after holding clock", statusActive, 1'b0);
    step();
    check("R11 no resume status", statusActive, 1'b0);
    check("R11 no resume holdReq", holdReq, 1'b0);

    finish();
  end
endmodule